// File: doc/BRIEF.md
# NAND DMA Command Sequencer

The sequencer sits between a host register port and a NAND flash DMA engine. The host issues a DMA command in one of two forms. The first is a set of four command-data pair words written to the data register. The second is one burst of four 16-bit beats. The sequencer collects the four 16-bit descriptor fields from either form and checks the ordering rules. Once the set is complete and the engine is idle, it presents the assembled descriptor to the engine. While DMA mode is on, host commands of any class other than the DMA class are refused. Ordinary commands of the DMA class are forwarded, but only between complete sets.

After launch the sequencer holds `busy` until the engine pulses `done`. If the descriptor's interrupt bit was set, it then raises a completion flag, which the host clears by writing one. A cache attribute register for the DMA master can be updated only while nothing is in flight. Every ordering violation sets a sticky error flag and discards the partial set.

Top module: `nand_dma_seq`

## Requirements
- R1: When DMA is enabled, a pair word is a write with `cmdMap`=2'b10, `cmdDataReg`=1, bits [31:28]=4'hA and bits [25:16]=0. Its slot number is bits [27:26] and its field value is bits [15:0]. Pairs written with slots 0,1,2,3 in that order form a set. In the cycle after the fourth pair, `descValid` is high when the engine is idle and not busy, and `descData[16k+15:16k]` holds the field of slot k.
- R2: A pair whose slot differs from the number of items already accepted in the current set sets `errFlag`, discards the partial set and is not stored. The next pair must again carry slot 0.
- R3: Any other command with `cmdMap`=2'b10 pulses `cmdFwd` for one cycle, one cycle after the write, provided no set is partly collected. If a set is partly collected, the command is not forwarded, `errFlag` is set and the partial set is discarded.
- R4: While `dmaEnable` is high, a command with `cmdMap` of 2'b00, 2'b01 or 2'b11 sets `errFlag` and is not forwarded. While `dmaEnable` is low, every command, of any class, is forwarded.
- R5: With DMA enabled, four `burstWrEn` beats build a descriptor in the same way as R1, where beat k supplies field k. Beats have no effect while `dmaEnable` is low.
- R6: Mixing the two forms inside one set, or asserting a command write in the same cycle as a beat, sets `errFlag` and discards the partial set.
- R7: `descValid` stays low while `engIdle` is low or `busy` is high. `busy` rises on the clock edge that ends a cycle with `descValid` high and falls on the edge that samples `done`.
- R8: Bit 8 of field 3 is the interrupt request. If it was 1 at launch, `cmdComp` rises on the edge that ends the transfer. If it was 0, `cmdComp` stays 0.
- R9: `compClr` clears `cmdComp`. When a completion and a clear land on the same edge, the completion wins.
- R10: A `cacheWrEn` write updates `cacheAttr` on the next edge only if `engIdle` is high and `busy` is low. Otherwise the write is refused and `cacheAttr` is unchanged.
- R11: `errFlag` stays high until `errClr` is asserted. A new error in the same cycle as the clear keeps it high.
- R12: While a complete descriptor is waiting for launch, any further pair or beat sets `errFlag`. The waiting descriptor is left intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dmaEnable | input | 1 | DMA mode is on |
| cmdWrEn | input | 1 | Host command write strobe |
| cmdMap | input | 2 | Command class of the write |
| cmdDataReg | input | 1 | The write targets the data register |
| cmdData | input | 32 | Host command write data |
| burstWrEn | input | 1 | Burst-form beat strobe |
| burstData | input | 16 | Burst-form beat data |
| engIdle | input | 1 | DMA engine reports idle |
| done | input | 1 | DMA engine reports the transfer finished |
| compClr | input | 1 | Write-one-to-clear for cmdComp |
| errClr | input | 1 | Clear for errFlag |
| cacheWrEn | input | 1 | Cache attribute write request |
| cacheWrData | input | 4 | Requested cache attribute |
| descValid | output | 1 | Descriptor launch strobe |
| descData | output | 64 | Assembled descriptor, four 16-bit fields |
| busy | output | 1 | Transfer in flight |
| cmdComp | output | 1 | Completion status flag |
| errFlag | output | 1 | Sticky sequence error |
| cmdFwd | output | 1 | Forwarded non-DMA command pulse |
| cacheAttr | output | 4 | Current cache attribute |

## Verification
Each write's effect on `errFlag`, `cmdFwd` and `cacheAttr` appears one edge after the write. The bench therefore applies a stimulus at a falling edge and reads the result at the next falling edge. `descValid` is a combinational decode of state. It is read in the same half-cycle that the fourth item's edge makes the set complete, or right after `engIdle` changes. `busy` is read one edge after that. `busy` and `cmdComp` are read one falling edge after `done` is applied. Sweeps cover every wrong slot at every set position and every class in both DMA modes.

// File: rtl/nand_dma_seq_pkg.sv
package nand_dma_seq_pkg;
  localparam int unsigned PAIR_COUNT = 4;
  localparam int unsigned SLOT_W     = $clog2(PAIR_COUNT);
  localparam int unsigned FIELD_W    = 16;
  localparam int unsigned HEAD_W     = 16;
  localparam int unsigned INT_POS    = 8;
  localparam logic [1:0]  DMA_CLASS  = 2'b10;
  localparam logic [3:0]  PAIR_TAG   = 4'hA;

  typedef struct packed {
    logic              fieldLoad;
    logic              fromBurst;
    logic [SLOT_W-1:0] fieldIdx;
    logic              cacheLoad;
  } ctlStrobes_t;
endpackage

// File: rtl/nand_dma_seq_ctrl.sv
module nand_dma_seq_ctrl
  import nand_dma_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dmaEnable,
  input  logic               cmdWrEn,
  input  logic [1:0]         cmdMap,
  input  logic               cmdDataReg,
  input  logic [HEAD_W-1:0]  cmdHead,
  input  logic               burstWrEn,
  input  logic               engIdle,
  input  logic               done,
  input  logic               compClr,
  input  logic               errClr,
  input  logic               cacheWrEn,
  input  logic               intBit,
  output ctlStrobes_t        strobes,
  output logic               descValid,
  output logic               busy,
  output logic               cmdComp,
  output logic               errFlag,
  output logic               cmdFwd
);
  localparam int unsigned RSV_W = HEAD_W - 4 - SLOT_W;

  logic [SLOT_W-1:0] slotCnt;
  logic setActive, setIsBurst, pending, busyQ, intArmed, compQ, errQ, fwdQ;
  logic pairWord, isPair, isBad, isFwd, isBeat;
  logic pairErr, beatErr, fwdErr, anyErr, takeItem, lastSlot, launch;
  logic [SLOT_W-1:0] pairIdx;

  always_comb begin
    pairWord = (cmdHead[HEAD_W-1 -: 4] == PAIR_TAG) && (cmdHead[RSV_W-1:0] == '0);
    pairIdx  = cmdHead[HEAD_W-5 -: SLOT_W];
    isPair   = cmdWrEn && dmaEnable && (cmdMap == DMA_CLASS) && cmdDataReg && pairWord;
    isBad    = cmdWrEn && dmaEnable && (cmdMap != DMA_CLASS);
    isFwd    = cmdWrEn && !isPair && !isBad;
    isBeat   = burstWrEn && dmaEnable;
    pairErr  = isPair && (isBeat || pending || (setActive && setIsBurst) || (pairIdx != slotCnt));
    beatErr  = isBeat && (pending || isFwd || isBad || (setActive && !setIsBurst));
    fwdErr   = isFwd && setActive;
    anyErr   = isBad || pairErr || beatErr || fwdErr;
    takeItem = (isPair || isBeat) && !anyErr;
    lastSlot = (slotCnt == SLOT_W'(PAIR_COUNT - 1));
    launch   = pending && engIdle && !busyQ;

    strobes.fieldLoad = takeItem;
    strobes.fromBurst = isBeat;
    strobes.fieldIdx  = slotCnt;
    strobes.cacheLoad = cacheWrEn && engIdle && !busyQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotCnt    <= '0;
      setActive  <= 1'b0;
      setIsBurst <= 1'b0;
      pending    <= 1'b0;
      busyQ      <= 1'b0;
      intArmed   <= 1'b0;
      compQ      <= 1'b0;
      errQ       <= 1'b0;
      fwdQ       <= 1'b0;
    end else begin
      fwdQ <= isFwd && !anyErr;
      if (anyErr) begin
        slotCnt   <= '0;
        setActive <= 1'b0;
      end else if (takeItem) begin
        setIsBurst <= isBeat;
        if (lastSlot) begin
          slotCnt   <= '0;
          setActive <= 1'b0;
        end else begin
          slotCnt   <= slotCnt + 1'b1;
          setActive <= 1'b1;
        end
      end
      if (takeItem && lastSlot) pending <= 1'b1;
      else if (launch)          pending <= 1'b0;
      if (launch) begin
        busyQ    <= 1'b1;
        intArmed <= intBit;
      end else if (done) begin
        busyQ <= 1'b0;
      end
      compQ <= (compQ && !compClr) || (busyQ && done && intArmed);
      errQ  <= (errQ && !errClr) || anyErr;
    end
  end

  assign descValid = launch;
  assign busy      = busyQ;
  assign cmdComp   = compQ;
  assign errFlag   = errQ;
  assign cmdFwd    = fwdQ;
endmodule

// File: rtl/nand_dma_seq_dp.sv
module nand_dma_seq_dp
  import nand_dma_seq_pkg::*;
#(
  parameter int unsigned CACHE_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  ctlStrobes_t                   strobes,
  input  logic [FIELD_W-1:0]            cmdField,
  input  logic [FIELD_W-1:0]            burstData,
  input  logic [CACHE_W-1:0]            cacheWrData,
  output logic [PAIR_COUNT*FIELD_W-1:0] descData,
  output logic                          intBit,
  output logic [CACHE_W-1:0]            cacheAttr
);
  logic [FIELD_W-1:0] fieldIn;
  assign fieldIn = strobes.fromBurst ? burstData : cmdField;

  for (genvar g = 0; g < PAIR_COUNT; g++) begin : gSlot
    logic [FIELD_W-1:0] slotQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slotQ <= '0;
      else if (strobes.fieldLoad && (strobes.fieldIdx == SLOT_W'(g)))
        slotQ <= fieldIn;
    end
    assign descData[g*FIELD_W +: FIELD_W] = slotQ;
  end

  assign intBit = descData[(PAIR_COUNT-1)*FIELD_W + INT_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cacheAttr <= '0;
    else if (strobes.cacheLoad) cacheAttr <= cacheWrData;
  end
endmodule

// File: rtl/nand_dma_seq.sv
module nand_dma_seq
  import nand_dma_seq_pkg::*;
#(
  parameter int unsigned CACHE_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dmaEnable,
  input  logic                          cmdWrEn,
  input  logic [1:0]                    cmdMap,
  input  logic                          cmdDataReg,
  input  logic [31:0]                   cmdData,
  input  logic                          burstWrEn,
  input  logic [FIELD_W-1:0]            burstData,
  input  logic                          engIdle,
  input  logic                          done,
  input  logic                          compClr,
  input  logic                          errClr,
  input  logic                          cacheWrEn,
  input  logic [CACHE_W-1:0]            cacheWrData,
  output logic                          descValid,
  output logic [PAIR_COUNT*FIELD_W-1:0] descData,
  output logic                          busy,
  output logic                          cmdComp,
  output logic                          errFlag,
  output logic                          cmdFwd,
  output logic [CACHE_W-1:0]            cacheAttr
);
  ctlStrobes_t strobes;
  logic        intBit;

  nand_dma_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .dmaEnable(dmaEnable),
    .cmdWrEn(cmdWrEn), .cmdMap(cmdMap), .cmdDataReg(cmdDataReg),
    .cmdHead(cmdData[31 -: HEAD_W]), .burstWrEn(burstWrEn),
    .engIdle(engIdle), .done(done), .compClr(compClr), .errClr(errClr),
    .cacheWrEn(cacheWrEn), .intBit(intBit), .strobes(strobes),
    .descValid(descValid), .busy(busy), .cmdComp(cmdComp),
    .errFlag(errFlag), .cmdFwd(cmdFwd)
  );

  nand_dma_seq_dp #(.CACHE_W(CACHE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .cmdField(cmdData[FIELD_W-1:0]), .burstData(burstData),
    .cacheWrData(cacheWrData), .descData(descData),
    .intBit(intBit), .cacheAttr(cacheAttr)
  );
endmodule

// File: rtl/nand_dma_seq_chk.sv
module nand_dma_seq_chk #(
  parameter int unsigned CACHE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dmaEnable,
  input logic               cmdWrEn,
  input logic [1:0]         cmdMap,
  input logic               engIdle,
  input logic               done,
  input logic               errClr,
  input logic               descValid,
  input logic               busy,
  input logic               cmdComp,
  input logic               errFlag,
  input logic [CACHE_W-1:0] cacheAttr
);
  // R7
  busy_after_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    descValid |=> busy);
  // R7
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> !busy);
  // R7
  no_launch_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !descValid);
  // R4
  bad_class_errs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWrEn && dmaEnable && cmdMap != 2'b10) |=> errFlag);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (errFlag && !errClr) |=> errFlag);
  // R8
  comp_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmdComp) |-> $past(busy && done));
  // R10
  cache_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cacheAttr) |-> $past(engIdle && !busy));
endmodule

bind nand_dma_seq nand_dma_seq_chk #(.CACHE_W(CACHE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dmaEnable(dmaEnable), .cmdWrEn(cmdWrEn),
  .cmdMap(cmdMap), .engIdle(engIdle), .done(done), .errClr(errClr),
  .descValid(descValid), .busy(busy), .cmdComp(cmdComp),
  .errFlag(errFlag), .cacheAttr(cacheAttr)
);

// File: tb/nand_dma_seq_tb.sv
`timescale 1ns/1ps
module nand_dma_seq_tb;
  localparam real CLK_NS = 20.0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dmaEnable = 1'b1, cmdWrEn = 1'b0, cmdDataReg = 1'b0, burstWrEn = 1'b0;
  logic [1:0] cmdMap = 2'b00;
  logic [31:0] cmdData = '0;
  logic [15:0] burstData = '0;
  logic engIdle = 1'b1, done = 1'b0, compClr = 1'b0, errClr = 1'b0, cacheWrEn = 1'b0;
  logic [3:0] cacheWrData = '0;
  logic descValid, busy, cmdComp, errFlag, cmdFwd;
  logic [63:0] descData;
  logic [3:0] cacheAttr;
  int nChecks = 0, nFails = 0;

  always #(CLK_NS/2) clk = ~clk;

  nand_dma_seq u_dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fieldVal(int seed, int k, bit intb);
    logic [15:0] f = 16'(seed * (k + 3) + 16'h0101 * k);
    if (k == 3) f[8] = intb;
    return f;
  endfunction

  function automatic logic [63:0] expDesc(int seed, bit intb);
    logic [63:0] d;
    for (int k = 0; k < 4; k++) d[16*k +: 16] = fieldVal(seed, k, intb);
    return d;
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic wrCmd(logic [1:0] m, logic dreg, logic [31:0] d);
    cmdWrEn = 1'b1; cmdMap = m; cmdDataReg = dreg; cmdData = d;
    tick();
    cmdWrEn = 1'b0;
  endtask

  task automatic wrPair(int slot, logic [15:0] f);
    wrCmd(2'b10, 1'b1, {4'hA, 2'(slot), 10'b0, f});
  endtask

  task automatic wrBeat(logic [15:0] f);
    burstWrEn = 1'b1; burstData = f;
    tick();
    burstWrEn = 1'b0;
  endtask

  task automatic clearErr();
    errClr = 1'b1; tick(); errClr = 1'b0;
  endtask

  task automatic fullSet(int seed, bit intb, bit useBurst);
    for (int k = 0; k < 4; k++)
      if (useBurst) wrBeat(fieldVal(seed, k, intb));
      else          wrPair(k, fieldVal(seed, k, intb));
  endtask

  task automatic finishXfer();
    done = 1'b1; tick(); done = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("reset busy", {63'b0, busy}, 0);
    chk("reset descValid", {63'b0, descValid}, 0);
    chk("reset flags", {61'b0, cmdComp, errFlag, cmdFwd}, 0);
    chk("reset cacheAttr", {60'b0, cacheAttr}, 0);

    // R1 R7 R8: pair set with interrupt cleared
    fullSet(7, 1'b0, 1'b0);
    chk("R1 descValid", {63'b0, descValid}, 1);
    chk("R1 descData", descData, expDesc(7, 1'b0));
    tick();
    chk("R7 busy after launch", {63'b0, busy}, 1);
    finishXfer();
    chk("R7 busy after done", {63'b0, busy}, 0);
    chk("R8 no comp when int=0", {63'b0, cmdComp}, 0);

    // R2: each wrong slot at each position, then recovery
    for (int pos = 0; pos < 4; pos++)
      for (int bad = 0; bad < 4; bad++) begin
        if (bad == pos) continue;
        for (int k = 0; k < pos; k++) wrPair(k, 16'h5A00 + 16'(k));
        wrPair(bad, 16'hDEAD);
        chk($sformatf("R2 error pos%0d slot%0d", pos, bad), {63'b0, errFlag}, 1);
        clearErr();
        fullSet(pos * 4 + bad + 11, 1'b0, 1'b0);
        chk("R2 recovery desc", descData, expDesc(pos * 4 + bad + 11, 1'b0));
        chk("R2 recovery launch", {63'b0, descValid}, 1);
        tick();
        finishXfer();
      end

    // R4 R3: every class in both DMA modes
    for (int dm = 0; dm < 2; dm++)
      for (int cls = 0; cls < 4; cls++) begin
        dmaEnable = 1'(dm);
        wrCmd(2'(cls), 1'b1, 32'h0000_1234);
        chk($sformatf("R4 fwd dma%0d cls%0d", dm, cls), {63'b0, cmdFwd},
            (dm == 0 || cls == 2) ? 64'd1 : 64'd0);
        chk($sformatf("R4 err dma%0d cls%0d", dm, cls), {63'b0, errFlag},
            (dm == 1 && cls != 2) ? 64'd1 : 64'd0);
        clearErr();
      end
    dmaEnable = 1'b1;

    // R3: forwarding mid-set is an error
    wrPair(0, 16'h1); wrPair(1, 16'h2);
    wrCmd(2'b10, 1'b0, 32'h0000_00FF);
    chk("R3 mid-set not forwarded", {63'b0, cmdFwd}, 0);
    chk("R3 mid-set error", {63'b0, errFlag}, 1);
    // R11: sticky across idle cycles
    repeat (3) tick();
    chk("R11 still set", {63'b0, errFlag}, 1);
    clearErr();
    chk("R11 cleared", {63'b0, errFlag}, 0);
    fullSet(40, 1'b0, 1'b0);
    chk("R3 set discarded then fresh", descData, expDesc(40, 1'b0));
    tick(); finishXfer();

    // R5: burst form with interrupt set, R8 completion, R9 clear
    fullSet(55, 1'b1, 1'b1);
    chk("R5 burst descValid", {63'b0, descValid}, 1);
    chk("R5 burst descData", descData, expDesc(55, 1'b1));
    tick();
    finishXfer();
    chk("R8 comp set", {63'b0, cmdComp}, 1);
    compClr = 1'b1; tick(); compClr = 1'b0;
    chk("R9 comp cleared", {63'b0, cmdComp}, 0);

    // R5: beats ignored while DMA disabled
    dmaEnable = 1'b0;
    for (int k = 0; k < 4; k++) wrBeat(16'hBEEF);
    chk("R5 disabled no launch", {63'b0, descValid}, 0);
    chk("R5 disabled no error", {63'b0, errFlag}, 0);
    dmaEnable = 1'b1;
    fullSet(61, 1'b0, 1'b0);
    chk("R5 no leftover state", descData, expDesc(61, 1'b0));
    tick(); finishXfer();

    // R6: mixing forms
    wrPair(0, 16'h3);
    wrBeat(16'h4);
    chk("R6 pair then beat", {63'b0, errFlag}, 1);
    clearErr();
    wrBeat(16'h4);
    wrPair(1, 16'h3);
    chk("R6 beat then pair", {63'b0, errFlag}, 1);
    clearErr();
    cmdWrEn = 1'b1; cmdMap = 2'b10; cmdDataReg = 1'b1; cmdData = {4'hA, 2'd0, 26'h5};
    burstWrEn = 1'b1;
    tick();
    cmdWrEn = 1'b0; burstWrEn = 1'b0;
    chk("R6 same-cycle write and beat", {63'b0, errFlag}, 1);
    clearErr();

    // R7 R12: pending while engine not idle
    engIdle = 1'b0;
    fullSet(70, 1'b1, 1'b0);
    chk("R7 held while engine busy", {63'b0, descValid}, 0);
    wrPair(0, 16'h9);
    chk("R12 write while pending", {63'b0, errFlag}, 1);
    wrBeat(16'h9);
    chk("R12 still set", {63'b0, errFlag}, 1);
    clearErr();
    engIdle = 1'b1;
    #1;
    chk("R12 pending launches", {63'b0, descValid}, 1);
    chk("R12 pending intact", descData, expDesc(70, 1'b1));
    tick();
    chk("R7 busy", {63'b0, busy}, 1);

    // R10: cache writes refused while busy, and while engine not idle
    cacheWrEn = 1'b1; cacheWrData = 4'h9; tick(); cacheWrEn = 1'b0;
    chk("R10 refused while busy", {60'b0, cacheAttr}, 0);

    // R7: second set waits for busy to drop
    fullSet(80, 1'b0, 1'b0);
    chk("R7 held while busy", {63'b0, descValid}, 0);
    // R9: completion wins over clear
    compClr = 1'b1; done = 1'b1; tick(); compClr = 1'b0; done = 1'b0;
    chk("R9 set wins", {63'b0, cmdComp}, 1);
    chk("R7 launch after done", {63'b0, descValid}, 1);
    chk("R7 second desc", descData, expDesc(80, 1'b0));
    tick(); finishXfer();
    compClr = 1'b1; tick(); compClr = 1'b0;

    engIdle = 1'b0;
    cacheWrEn = 1'b1; cacheWrData = 4'h6; tick(); cacheWrEn = 1'b0;
    chk("R10 refused engine not idle", {60'b0, cacheAttr}, 0);
    engIdle = 1'b1;
    cacheWrEn = 1'b1; cacheWrData = 4'hC; tick(); cacheWrEn = 1'b0;
    chk("R10 accepted when idle", {60'b0, cacheAttr}, 64'hC);

    // R11: error and clear together keep flag
    errClr = 1'b1; wrCmd(2'b01, 1'b0, 32'h0); errClr = 1'b0;
    chk("R11 new error beats clear", {63'b0, errFlag}, 1);
    clearErr();

    summary();
    $finish;
  end
endmodule